// File: doc/BRIEF.md
# Latched Dual Interval Timer

Two 16-bit down-counters sit behind a byte-wide register port. Software writes a reload value one byte at a time. The write of the high byte starts a count. Each counter then decrements on every clock cycle in which the tick-enable input is high. A timer raises its interrupt flag on the tick that brings its count to zero. The flag stays high until a register access clears it.

The first timer keeps a 16-bit latch. After its count reaches zero it shows 0xFFFF for one tick, then reloads from the latch, so a full period lasts latch+2 ticks. A control bit selects the flag behaviour. In one-shot mode the flag is raised once per start. In continuous mode it is raised on every period. The second timer is always one-shot. It keeps decrementing through 0xFFFF without a reload and does not flag again until software starts it once more.

Register reads return data in the same cycle as the read strobe. Reads and writes of some addresses have side effects: reading a count low byte acknowledges that timer, and writing a high byte clears a flag.

Top module: `dual_ivl_timer`

## Requirements
- R1: After reset, the first timer's latch and count read 0xFFFF, the second timer's count reads 0xFFFF, the control register reads 0x00 (one-shot), and both flags are low.
- R2: A write to address 0x0 or 0x2 replaces only the low byte of the first timer's latch and leaves its running count unchanged. Address 0x2 reads the latch low byte and address 0x3 reads the latch high byte.
- R3: A write to address 0x3 replaces the latch high byte and clears the first timer's flag. It does not reload the count.
- R4: A write to address 0x1 replaces the latch high byte, loads the count with {written byte, latch low byte} and clears the first timer's flag. The new count is visible in the next cycle.
- R5: A count changes only on a clock edge where tick_en is high, or on a start write.
- R6: When the first timer ticks from 0 it shows 0xFFFF, and on the next tick it shows the latch value. The zero count therefore recurs every latch+2 ticks.
- R7: The first timer's flag rises on the tick that brings its count to 0. In continuous mode this happens on every period. In one-shot mode it happens only on the first zero after each write to address 0x1.
- R8: rdata is combinational. It returns the selected byte while rd_en is high and 0x00 while rd_en is low. Reading 0x0 or 0x4 returns that timer's count low byte and clears its flag at the clock edge. Reading 0x1 or 0x5 returns the count high byte and leaves the flag unchanged.
- R9: A write to 0x4 stores the second timer's latch low byte, which resets to 0xFF. A write to 0x5 loads the second timer's count with {written byte, latch low byte}, clears its flag, and arms a single flag at the next zero. After that zero the count wraps through 0xFFFF without reloading.
- R10: A start write (0x1 or 0x5) in the same cycle as a zero-reaching tick wins: the count loads and the flag ends low. A zero-reaching tick in the same cycle as an acknowledging read or a write to 0x3 leaves the flag high.
- R11: Bit 0 of the control register at address 0x6 selects continuous mode when set. The register reads back as {7'b0, mode bit}. Addresses 0x7 to 0xF read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counters |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counters decrement on cycles where this is high |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, which also triggers read side effects |
| rdata | output | 8 | Read data, combinational from addr and rd_en |
| t1_irq | output | 1 | First timer interrupt flag |
| t2_irq | output | 1 | Second timer interrupt flag |

## Verification
Writes, ticks and acknowledges act on the rising edge, so their effect on a count or a flag is due one cycle after the stimulus. Read data belongs to the same cycle as its strobe. The bench drives each input one nanosecond after a rising edge and samples rdata and both flags at the following falling edge. It then advances its reference model across the rising edge, so every comparison uses the state before the edge for read data and the state after the previous edge for flags. Directed sequences place the zero-reaching tick in the same cycle as a load, an acknowledge or a latch-high write, to test the priority rules.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int CNT_W    = 2 * DATA_W;
    localparam int N_TMR    = 2;
    localparam int MODE_BIT = 0;

    // Register addresses; the rest of the space reads as zero
    typedef enum logic [ADDR_W-1:0] {
        A_T1_CLO = 4'h0,
        A_T1_CHI = 4'h1,
        A_T1_LLO = 4'h2,
        A_T1_LHI = 4'h3,
        A_T2_CLO = 4'h4,
        A_T2_CHI = 4'h5,
        A_MODE   = 4'h6
    } reg_addr_e;

    // Per-timer control decoded from the register port
    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] load_val;
        logic             ack;
        logic             clr;
    } tmr_ctl_t;

    function automatic logic [DATA_W-1:0] lo_byte(input logic [CNT_W-1:0] v);
        return v[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
        return v[CNT_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter bit RELOAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cont_mode,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             flag
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic             wrap_q;
    logic             armed_q;
    logic             flag_q;
    logic             hit;

    // A reloading slice takes the latch one tick after passing through all-ones
    assign step = (RELOAD && wrap_q) ? reload_val : cnt_q - CNT_W'(1);
    assign hit  = tick_en && !ctl.load && (step == '0) && (cont_mode || armed_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            wrap_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (ctl.load) begin
            cnt_q   <= ctl.load_val;
            wrap_q  <= 1'b0;
            armed_q <= 1'b1;
        end else if (tick_en) begin
            cnt_q  <= step;
            wrap_q <= (cnt_q == '0);
            if (hit) begin
                armed_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (ctl.load) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (ctl.ack || ctl.clr) begin
            flag_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign flag  = flag_q;

endmodule

// File: rtl/dual_ivl_timer.sv
module dual_ivl_timer
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              t1_irq,
    output logic              t2_irq
);

    logic [CNT_W-1:0]  t1_latch;
    logic [DATA_W-1:0] t2_lat_lo;
    logic              mode_cont;

    tmr_ctl_t          ctl        [N_TMR];
    logic [CNT_W-1:0]  cnt        [N_TMR];
    logic [CNT_W-1:0]  reload_src [N_TMR];
    logic [N_TMR-1:0]  cont_sel;
    logic [N_TMR-1:0]  flag;

    // Register-port decode into per-timer controls
    always_comb begin
        ctl[0] = '{load:     wr_en && (addr == A_T1_CHI),
                   load_val: {wdata, t1_latch[DATA_W-1:0]},
                   ack:      rd_en && (addr == A_T1_CLO),
                   clr:      wr_en && (addr == A_T1_LHI)};
        ctl[1] = '{load:     wr_en && (addr == A_T2_CHI),
                   load_val: {wdata, t2_lat_lo},
                   ack:      rd_en && (addr == A_T2_CLO),
                   clr:      1'b0};
        reload_src[0] = t1_latch;
        reload_src[1] = '1;
        cont_sel      = {1'b0, mode_cont};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_latch  <= '1;
            t2_lat_lo <= '1;
            mode_cont <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_T1_CLO, A_T1_LLO: t1_latch[DATA_W-1:0]     <= wdata;
                A_T1_CHI, A_T1_LHI: t1_latch[CNT_W-1:DATA_W] <= wdata;
                A_T2_CLO:           t2_lat_lo                <= wdata;
                A_MODE:             mode_cont                <= wdata[MODE_BIT];
                default: ;
            endcase
        end
    end

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        ivt_timer #(
            .RELOAD (gi == 0)
        ) u_tmr (
            .clk        (clk),
            .rst        (rst),
            .tick_en    (tick_en),
            .cont_mode  (cont_sel[gi]),
            .ctl        (ctl[gi]),
            .reload_val (reload_src[gi]),
            .count      (cnt[gi]),
            .flag       (flag[gi])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_T1_CLO: rdata = lo_byte(cnt[0]);
                A_T1_CHI: rdata = hi_byte(cnt[0]);
                A_T1_LLO: rdata = lo_byte(t1_latch);
                A_T1_LHI: rdata = hi_byte(t1_latch);
                A_T2_CLO: rdata = lo_byte(cnt[1]);
                A_T2_CHI: rdata = hi_byte(cnt[1]);
                A_MODE:   rdata = {{(DATA_W-1){1'b0}}, mode_cont};
                default:  rdata = '0;
            endcase
        end
    end

    assign t1_irq = flag[0];
    assign t2_irq = flag[1];

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
    import ivt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic              t1_irq,
    input logic              t2_irq,
    input logic [CNT_W-1:0]  cnt1,
    input logic [CNT_W-1:0]  cnt2,
    input logic [CNT_W-1:0]  t1_latch
);

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(t1_latch)); // R2

    AST_LHI_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_T1_LHI && !tick_en) |=> ($stable(cnt1) && !t1_irq)); // R3

    AST_T1_START: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_T1_CHI) |=>
            (cnt1 == {$past(wdata), $past(t1_latch[DATA_W-1:0])}) && !t1_irq); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !(wr_en && (addr == A_T1_CHI || addr == A_T2_CHI)))
            |=> ($stable(cnt1) && $stable(cnt2))); // R5

    AST_T1_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && cnt1 == '0 && !(wr_en && addr == A_T1_CHI)) |=> (cnt1 == '1)); // R6

    AST_T1_RISE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(t1_irq) |-> (cnt1 == '0)); // R7

    AST_T1_ACK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_T1_CLO && !tick_en) |=> !t1_irq); // R8

    AST_T2_RISE_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(t2_irq) |-> (cnt2 == '0)); // R9

endmodule

bind dual_ivl_timer ivt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .t1_irq   (t1_irq),
    .t2_irq   (t2_irq),
    .cnt1     (cnt[0]),
    .cnt2     (cnt[1]),
    .t1_latch (t1_latch)
);

// File: tb/sim_dual_ivl_timer.sv
`timescale 1ns/1ps
module sim_dual_ivl_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       t1_irq;
    logic       t2_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dual_ivl_timer u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .t1_irq(t1_irq), .t2_irq(t2_irq)
    );

    // Reference model state
    logic [15:0] m_c1, m_c2, m_l1;
    logic [7:0]  m_l2;
    logic        m_mode, m_f1, m_f2, m_a1, m_a2, m_w1;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'h0:    return m_c1[7:0];
            4'h1:    return m_c1[15:8];
            4'h2:    return m_l1[7:0];
            4'h3:    return m_l1[15:8];
            4'h4:    return m_c2[7:0];
            4'h5:    return m_c2[15:8];
            4'h6:    return {7'b0, m_mode};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_reset;
        m_c1 = 16'hFFFF; m_c2 = 16'hFFFF; m_l1 = 16'hFFFF; m_l2 = 8'hFF;
        m_mode = 1'b0; m_f1 = 1'b0; m_f2 = 1'b0;
        m_a1 = 1'b0; m_a2 = 1'b0; m_w1 = 1'b0;
    endtask

    task automatic m_edge(input logic w, input logic r, input logic [3:0] a,
                          input logic [7:0] d, input logic t);
        logic [15:0] s1, s2;
        logic ld1, ld2, h1, h2;
        s1  = m_w1 ? m_l1 : m_c1 - 16'h0001;
        s2  = m_c2 - 16'h0001;
        ld1 = w && (a == 4'h1);
        ld2 = w && (a == 4'h5);
        h1  = t && !ld1 && (s1 == 16'h0000) && (m_mode || m_a1);
        h2  = t && !ld2 && (s2 == 16'h0000) && m_a2;
        if (ld1) m_f1 = 1'b0;
        else if (h1) m_f1 = 1'b1;
        else if ((r && a == 4'h0) || (w && a == 4'h3)) m_f1 = 1'b0;
        if (ld2) m_f2 = 1'b0;
        else if (h2) m_f2 = 1'b1;
        else if (r && a == 4'h4) m_f2 = 1'b0;
        if (ld1) begin
            m_c1 = {d, m_l1[7:0]}; m_w1 = 1'b0; m_a1 = 1'b1;
        end else if (t) begin
            m_w1 = (m_c1 == 16'h0000); m_c1 = s1;
        end
        if (h1) m_a1 = 1'b0;
        if (ld2) begin
            m_c2 = {d, m_l2}; m_a2 = 1'b1;
        end else if (t) begin
            m_c2 = s2;
        end
        if (h2) m_a2 = 1'b0;
        if (w) begin
            case (a)
                4'h0, 4'h2: m_l1[7:0]  = d;
                4'h1, 4'h3: m_l1[15:8] = d;
                4'h4:       m_l2       = d;
                4'h6:       m_mode     = d[0];
                default: ;
            endcase
        end
    endtask

    // One clock cycle: drive, sample at falling edge, advance model at rising edge
    task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d,
                       input logic t, input string rtag, output logic [7:0] got);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
        @(negedge clk);
        got = rdata;
        check(rtag, 16'(rdata), 16'(r ? m_read(a) : 8'h00));
        check("R7 t1 flag vs model", 16'(t1_irq), 16'(m_f1));
        check("R9 t2 flag vs model", 16'(t2_irq), 16'(m_f2));
        @(posedge clk);
        m_edge(w, r, a, d, t);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic t = 1'b0);
        logic [7:0] g;
        cyc(1'b1, 1'b0, a, d, t, "R8 idle rdata", g);
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag,
                      input logic t = 1'b0);
        logic [7:0] g;
        cyc(1'b0, 1'b1, a, 8'h00, t, "R8 read vs model", g);
        check(tag, 16'(g), 16'(exp));
    endtask

    task automatic tick(input int n);
        logic [7:0] g;
        repeat (n) cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, "R5 idle rdata", g);
    endtask

    task automatic fchk(input logic act, input logic exp, input string tag);
        check(tag, 16'(act), 16'(exp));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  g;
        logic [3:0]  ra;
        logic [7:0]  rd8;
        logic        rt;
        int unsigned op;
        void'($urandom(32'd20240607));
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        fchk(t1_irq, 1'b0, "R1 t1 flag after reset");
        fchk(t2_irq, 1'b0, "R1 t2 flag after reset");
        rd(4'h2, 8'hFF, "R1 latch low");
        rd(4'h3, 8'hFF, "R1 latch high");
        rd(4'h0, 8'hFF, "R1 t1 count low");
        rd(4'h1, 8'hFF, "R1 t1 count high");
        rd(4'h5, 8'hFF, "R1 t2 count high");
        rd(4'h6, 8'h00, "R1 control");

        // R2 low latch writes leave count alone
        wr(4'h2, 8'h40);
        wr(4'h0, 8'h03);
        rd(4'h2, 8'h03, "R2 latch low readback");
        rd(4'h0, 8'hFF, "R2 count unchanged");

        // R3 latch high write does not reload
        wr(4'h3, 8'h00);
        rd(4'h3, 8'h00, "R3 latch high readback");
        rd(4'h1, 8'hFF, "R3 count not reloaded");

        // R4 start write loads count
        wr(4'h1, 8'h00);
        rd(4'h0, 8'h03, "R4 count low loaded");
        rd(4'h1, 8'h00, "R4 count high loaded");
        fchk(t1_irq, 1'b0, "R4 flag low after start");

        // R5 no tick, no change
        repeat (4) cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, "R5 idle rdata", g);
        rd(4'h0, 8'h03, "R5 count held");

        // R6/R7 continuous period
        wr(4'h6, 8'h01);
        tick(3);
        fchk(t1_irq, 1'b1, "R7 continuous first zero");
        rd(4'h0, 8'h00, "R8 ack read at zero");
        fchk(t1_irq, 1'b0, "R8 ack clears t1 flag");
        tick(1);
        rd(4'h1, 8'hFF, "R6 all-ones step high");
        rd(4'h0, 8'hFF, "R6 all-ones step low");
        tick(1);
        rd(4'h0, 8'h03, "R6 reload from latch");
        tick(3);
        fchk(t1_irq, 1'b1, "R7 continuous repeat after latch+2");

        // R7 one-shot
        wr(4'h6, 8'h00);
        rd(4'h0, 8'h00, "R8 ack before one-shot");
        wr(4'h1, 8'h00);
        tick(3);
        fchk(t1_irq, 1'b1, "R7 one-shot first zero");
        rd(4'h0, 8'h00, "R7 one-shot ack");
        tick(5);
        rd(4'h0, 8'h00, "R7 one-shot back at zero");
        fchk(t1_irq, 1'b0, "R7 one-shot no second flag");

        // R9 second timer
        wr(4'h4, 8'h02);
        wr(4'h5, 8'h00);
        rd(4'h4, 8'h02, "R9 t2 loaded");
        tick(2);
        fchk(t2_irq, 1'b1, "R9 t2 flag at zero");
        rd(4'h5, 8'h00, "R8 t2 high read");
        fchk(t2_irq, 1'b1, "R8 high read keeps t2 flag");
        rd(4'h4, 8'h00, "R8 t2 low read");
        fchk(t2_irq, 1'b0, "R8 low read clears t2 flag");
        tick(3);
        rd(4'h5, 8'hFF, "R9 t2 wraps high");
        rd(4'h4, 8'hFD, "R9 t2 wraps low no reload");
        fchk(t2_irq, 1'b0, "R9 t2 no second flag");

        // R10 priorities
        wr(4'h6, 8'h01);
        wr(4'h1, 8'h00);
        tick(2);
        rd(4'h0, 8'h01, "R10 read during hit", 1'b1);
        fchk(t1_irq, 1'b1, "R10 hit beats ack");
        tick(4);
        wr(4'h1, 8'h00, 1'b1);
        fchk(t1_irq, 1'b0, "R10 start beats hit");
        rd(4'h0, 8'h03, "R10 start loaded count");
        tick(2);
        wr(4'h3, 8'h00, 1'b1);
        fchk(t1_irq, 1'b1, "R10 hit beats latch-high clear");

        // R11 control and unmapped addresses
        wr(4'h6, 8'hFF);
        rd(4'h6, 8'h01, "R11 control reads bit0 only");
        wr(4'h9, 8'h55);
        rd(4'h9, 8'h00, "R11 unmapped read");
        rd(4'h7, 8'h00, "R11 unmapped 7");
        rd(4'hF, 8'h00, "R11 unmapped F");
        rd(4'h2, 8'h03, "R11 latch low untouched");
        rd(4'h3, 8'h00, "R11 latch high untouched");

        // Constrained random against the model
        for (int i = 0; i < 4000; i++) begin
            ra  = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 6)) : 4'($urandom_range(0, 15));
            rd8 = 8'($urandom);
            if ((ra == 4'h1 || ra == 4'h3 || ra == 4'h5) && $urandom_range(0, 9) != 0) rd8 = 8'h00;
            if ((ra == 4'h0 || ra == 4'h2 || ra == 4'h4) && $urandom_range(0, 1) != 0) rd8 = rd8 & 8'h0F;
            rt  = ($urandom_range(0, 3) != 0);
            op  = $urandom_range(0, 2);
            cyc(op == 1, op == 2, ra, rd8, rt, "R8 random read", g);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule